// File: doc/BRIEF.md
# Hyperframe Control Word Insertion Table

This block sits in the transmit path of a radio-link framer. It keeps one stored control word for every control-word position of a 256-position hyperframe. For each position it also keeps a bit that says whether the stored word should replace the word the framer would otherwise send. Software fills the table through a small write-only register port. It first points an index register at an entry and a section. It then writes that 32-bit section through a data register. Finally it commits the entry with an insert bit. How many sections make up a control word depends on the configured line rate.

During transmission the framer pulses a slot strobe once per control-word slot and presents its own default word. A position counter follows the hyperframe and picks the matching table entry. If that entry is enabled and the master insert enable is also set, the stored sections replace the default word. Otherwise the default word is sent unchanged. Software reaches the vendor-specific positions, which sit at indices N + 64·k for k = 0..3, through the same sequence as any other entry.

Top module: `hfcw_inject`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `tx_cw_vld` and `tx_cw_ins` are 0 and `tx_cw` is all zeros. Reset clears the master enable and every entry enable.
- R2: `tx_cw_vld` is 1 in exactly the cycle after a cycle with `slot_stb` high and is 0 otherwise. `tx_cw` and `tx_cw_ins` are valid in that cycle.
- R3: The k-th slot strobe after reset (counting from 0) addresses table entry k mod 256, so the position wraps from 255 to 0.
- R4: When the master enable is clear, or the addressed entry is disabled, `tx_cw` equals the `dflt_cw` presented with the strobe and `tx_cw_ins` is 0.
- R5: When the master enable and the addressed entry's enable are both set, `tx_cw_ins` is 1. Each section s (bits 32·s+31..32·s) below the active section count comes from the table. Higher sections come from `dflt_cw`.
- R6: The active section count follows `rate_sel`: 0→1, 1→2, 2→3, 3→4, and 4 to 7→5. It is taken at the time of the write or of the strobe.
- R7: A data write whose sequence field is at or above the active section count leaves the table unchanged.
- R8: Data writes and insert commits take effect only while `sync_state` equals 6. At any other state they are ignored. Index field writes and config writes are always accepted.
- R9: An index-register write (`reg_addr`=0) changes only the fields whose enables are set. `reg_fld_en[0]` selects the entry number (bits 7..0). `reg_fld_en[1]` selects the sequence (bits 10..8). `reg_fld_en[2]` selects the insert commit (bit 16), which applies to the entry number as updated by the same write. A data write (`reg_addr`=1) stores all 32 bits. A config write (`reg_addr`=2) sets the master enable to bit 0.
- R10: An insert commit with bit 16 = 0 disables the selected entry, so its position reverts to pass-through.
- R11: Entries are independent. Programming the four vendor positions 16, 80, 144 and 208 changes the output at those positions only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 index, 1 data, 2 config |
| reg_fld_en | input | 3 | Field enables for index-register writes |
| reg_wdata | input | 32 | Register write data |
| sync_state | input | 3 | Layer-1 sync state, 6 = synchronized |
| rate_sel | input | 3 | Line-rate code selecting the section count |
| slot_stb | input | 1 | Control-word slot strobe |
| dflt_cw | input | 160 | Default control word for this slot |
| tx_cw | output | 160 | Outgoing control word |
| tx_cw_vld | output | 1 | Output valid, one cycle after the strobe |
| tx_cw_ins | output | 1 | Outgoing word came from the table |

## Verification
The hardest state to reach is a table entry that still holds sections left over from an earlier, wider rate after a narrower-rate rewrite, because the narrow rate hides those upper sections at the output. The bench fills an entry at the widest rate, rewrites all five sections at a narrow rate, and sweeps a hyperframe at the narrow rate. It then switches back to the widest rate and sweeps again, which shows that the rejected writes never landed. Every strobe of every sweep is compared against a bench model of the table, the enables and the position counter.

// File: rtl/hfcw_pkg.sv
package hfcw_pkg;

  typedef enum logic [1:0] {
    RA_INDEX  = 2'd0,
    RA_DATA   = 2'd1,
    RA_CONFIG = 2'd2
  } reg_addr_e;

  // Field positions inside the index register.
  localparam int IDX_SEQ_LSB = 8;
  localparam int IDX_INS_BIT = 16;

  // Number of 32-bit sections active for a given rate code.
  function automatic logic [7:0] sec_limit(input logic [7:0] rate, input logic [7:0] max_sec);
    logic [7:0] want;
    want = rate + 8'd1;
    return (want < max_sec) ? want : max_sec;
  endfunction

endpackage

// File: rtl/hfcw_regs.sv
module hfcw_regs
  import hfcw_pkg::*;
#(
  parameter int          IDX_W   = 8,
  parameter int          SEQ_W   = 3,
  parameter int          DATA_W  = 32,
  parameter int          RATE_W  = 3,
  parameter int          MAX_SEC = 5,
  parameter logic [2:0]  SYNC_OK = 3'd6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [2:0]        fld_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [2:0]        sync_state,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              master_en,
  output logic              ram_we,
  output logic [SEQ_W-1:0]  ram_sec,
  output logic [IDX_W-1:0]  ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              en_we,
  output logic              en_val,
  output logic [IDX_W-1:0]  en_addr
);

  logic [IDX_W-1:0] entry_q;
  logic [SEQ_W-1:0] seq_q;
  logic             master_q;
  logic             synced;
  logic [7:0]       nsec;
  logic [IDX_W-1:0] entry_nxt;
  reg_addr_e        ra;

  assign ra        = reg_addr_e'(addr);
  assign synced    = (sync_state == SYNC_OK);
  assign nsec      = sec_limit(8'(rate_sel), 8'(MAX_SEC));
  assign entry_nxt = fld_en[0] ? wdata[IDX_W-1:0] : entry_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_q  <= '0;
      seq_q    <= '0;
      master_q <= 1'b0;
    end else if (wr_en) begin
      if (ra == RA_INDEX) begin
        entry_q <= entry_nxt;
        if (fld_en[1]) seq_q <= wdata[IDX_SEQ_LSB +: SEQ_W];
      end
      if (ra == RA_CONFIG) master_q <= wdata[0];
    end
  end

  always_comb begin
    ram_we    = wr_en && (ra == RA_DATA) && synced && (8'(seq_q) < nsec);
    ram_sec   = seq_q;
    ram_addr  = entry_q;
    ram_wdata = wdata;
    en_we     = wr_en && (ra == RA_INDEX) && fld_en[2] && synced;
    en_val    = wdata[IDX_INS_BIT];
    en_addr   = entry_nxt;
  end

  assign master_en = master_q;

endmodule

// File: rtl/hfcw_sec_ram.sv
module hfcw_sec_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/hfcw_enable_bits.sv
module hfcw_enable_bits #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wval,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          rd_q
);

  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      if (we) bits_q[waddr] <= wval;
      if (re) rd_q <= bits_q[raddr];
    end
  end

endmodule

// File: rtl/hfcw_slot_ctr.sv
module hfcw_slot_ctr #(
  parameter int SLOTS = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  output logic [AW-1:0] pos
);

  localparam logic [AW-1:0] LAST = AW'(SLOTS - 1);

  always_ff @(posedge clk) begin
    if (rst)      pos <= '0;
    else if (stb) pos <= (pos == LAST) ? '0 : pos + 1'b1;
  end

endmodule

// File: rtl/hfcw_inject.sv
module hfcw_inject
  import hfcw_pkg::*;
#(
  parameter int         ENTRIES = 256,
  parameter int         SEC_W   = 32,
  parameter int         MAX_SEC = 5,
  parameter int         RATE_W  = 3,
  parameter logic [2:0] SYNC_OK = 3'd6,
  localparam int        CW_W    = SEC_W * MAX_SEC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [2:0]        reg_fld_en,
  input  logic [SEC_W-1:0]  reg_wdata,
  input  logic [2:0]        sync_state,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              slot_stb,
  input  logic [CW_W-1:0]   dflt_cw,
  output logic [CW_W-1:0]   tx_cw,
  output logic              tx_cw_vld,
  output logic              tx_cw_ins
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int SEQ_W = $clog2(MAX_SEC);

  logic [IDX_W-1:0] pos;
  logic             master_en;
  logic             ram_we;
  logic [SEQ_W-1:0] ram_sec;
  logic [IDX_W-1:0] ram_addr;
  logic [SEC_W-1:0] ram_wdata;
  logic             en_we;
  logic             en_val;
  logic [IDX_W-1:0] en_addr;
  logic             en_rd_q;
  logic [SEC_W-1:0] rd_sec [MAX_SEC];
  logic             vld_q;
  logic             mst_q;
  logic [7:0]       nsec_q;
  logic [CW_W-1:0]  dflt_q;
  logic             ins;

  hfcw_regs #(
    .IDX_W(IDX_W), .SEQ_W(SEQ_W), .DATA_W(SEC_W), .RATE_W(RATE_W),
    .MAX_SEC(MAX_SEC), .SYNC_OK(SYNC_OK)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr),
    .fld_en(reg_fld_en), .wdata(reg_wdata), .sync_state(sync_state),
    .rate_sel(rate_sel), .master_en(master_en), .ram_we(ram_we),
    .ram_sec(ram_sec), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .en_we(en_we), .en_val(en_val), .en_addr(en_addr)
  );

  hfcw_slot_ctr #(.SLOTS(ENTRIES), .AW(IDX_W)) u_ctr (
    .clk(clk), .rst(rst), .stb(slot_stb), .pos(pos)
  );

  hfcw_enable_bits #(.DEPTH(ENTRIES), .AW(IDX_W)) u_en (
    .clk(clk), .rst(rst), .we(en_we), .waddr(en_addr), .wval(en_val),
    .re(slot_stb), .raddr(pos), .rd_q(en_rd_q)
  );

  // One narrow RAM per section keeps every write a plain single-port write.
  for (genvar s = 0; s < MAX_SEC; s++) begin : g_sec
    logic sec_we;
    assign sec_we = ram_we && (ram_sec == SEQ_W'(s));

    hfcw_sec_ram #(.DEPTH(ENTRIES), .AW(IDX_W), .DW(SEC_W)) u_ram (
      .clk(clk), .we(sec_we), .waddr(ram_addr), .wdata(ram_wdata),
      .re(slot_stb), .raddr(pos), .rdata(rd_sec[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      mst_q  <= 1'b0;
      nsec_q <= '0;
      dflt_q <= '0;
    end else begin
      vld_q <= slot_stb;
      if (slot_stb) begin
        mst_q  <= master_en;
        nsec_q <= sec_limit(8'(rate_sel), 8'(MAX_SEC));
        dflt_q <= dflt_cw;
      end
    end
  end

  assign ins = vld_q && mst_q && en_rd_q;

  for (genvar s = 0; s < MAX_SEC; s++) begin : g_mux
    assign tx_cw[s*SEC_W +: SEC_W] =
      (ins && (8'(s) < nsec_q)) ? rd_sec[s] : dflt_q[s*SEC_W +: SEC_W];
  end

  assign tx_cw_vld = vld_q;
  assign tx_cw_ins = ins;

endmodule

// File: rtl/hfcw_inject_chk.sv
module hfcw_inject_chk
  import hfcw_pkg::*;
#(
  parameter int         CW_W    = 160,
  parameter int         SEQ_W   = 3,
  parameter int         RATE_W  = 3,
  parameter int         MAX_SEC = 5,
  parameter logic [2:0] SYNC_OK = 3'd6
) (
  input logic              clk,
  input logic              rst,
  input logic              slot_stb,
  input logic [CW_W-1:0]   dflt_cw,
  input logic [CW_W-1:0]   tx_cw,
  input logic              tx_cw_vld,
  input logic              tx_cw_ins,
  input logic [2:0]        sync_state,
  input logic [RATE_W-1:0] rate_sel,
  input logic              ram_we,
  input logic [SEQ_W-1:0]  ram_sec,
  input logic              en_we,
  input logic              master_en
);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> (!tx_cw_vld && !tx_cw_ins));

  a_r2_vld_after_stb: assert property (@(posedge clk) disable iff (rst)
    slot_stb |=> tx_cw_vld);

  a_r2_no_spurious_vld: assert property (@(posedge clk) disable iff (rst)
    !slot_stb |=> !tx_cw_vld);

  a_r4_passthru: assert property (@(posedge clk) disable iff (rst)
    (tx_cw_vld && !tx_cw_ins) |-> (tx_cw == $past(dflt_cw)));

  a_r5_needs_master: assert property (@(posedge clk) disable iff (rst)
    (tx_cw_vld && tx_cw_ins) |-> $past(master_en));

  a_r8_data_needs_sync: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (sync_state == SYNC_OK));

  a_r8_commit_needs_sync: assert property (@(posedge clk) disable iff (rst)
    en_we |-> (sync_state == SYNC_OK));

  a_r7_sec_in_range: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (8'(ram_sec) < sec_limit(8'(rate_sel), 8'(MAX_SEC))));

endmodule

bind hfcw_inject hfcw_inject_chk #(
  .CW_W(CW_W), .SEQ_W(SEQ_W), .RATE_W(RATE_W), .MAX_SEC(MAX_SEC), .SYNC_OK(SYNC_OK)
) u_chk (
  .clk(clk), .rst(rst), .slot_stb(slot_stb), .dflt_cw(dflt_cw), .tx_cw(tx_cw),
  .tx_cw_vld(tx_cw_vld), .tx_cw_ins(tx_cw_ins), .sync_state(sync_state),
  .rate_sel(rate_sel), .ram_we(ram_we), .ram_sec(ram_sec), .en_we(en_we),
  .master_en(master_en)
);

// File: tb/tb_hfcw_inject.sv
module tb_hfcw_inject;

  localparam int CLK_P = 10;
  localparam int NENT  = 256;
  localparam int NSEC  = 5;
  localparam int CW_W  = 32 * NSEC;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reg_wr_en = 1'b0;
  logic [1:0]      reg_addr = '0;
  logic [2:0]      reg_fld_en = '0;
  logic [31:0]     reg_wdata = '0;
  logic [2:0]      sync_state = '0;
  logic [2:0]      rate_sel = '0;
  logic            slot_stb = 1'b0;
  logic [CW_W-1:0] dflt_cw = '0;
  logic [CW_W-1:0] tx_cw;
  logic            tx_cw_vld;
  logic            tx_cw_ins;

  int checks = 0;
  int fails  = 0;
  int nstb   = 0;

  // Bench model
  logic [31:0] m_data [NENT][NSEC];
  bit          m_en [NENT];
  bit          m_master = 0;
  int          m_entry = 0;
  int          m_seq = 0;
  int          m_ptr = 0;

  hfcw_inject dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_fld_en(reg_fld_en), .reg_wdata(reg_wdata), .sync_state(sync_state),
    .rate_sel(rate_sel), .slot_stb(slot_stb), .dflt_cw(dflt_cw),
    .tx_cw(tx_cw), .tx_cw_vld(tx_cw_vld), .tx_cw_ins(tx_cw_ins)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int nsec_of(input int r);
    return (r >= 4) ? 5 : r + 1;
  endfunction

  function automatic logic [CW_W-1:0] mk_dflt(input int n);
    logic [CW_W-1:0] v;
    for (int s = 0; s < NSEC; s++)
      v[s*32 +: 32] = {8'hD5, 16'(n), 8'(s)};
    return v;
  endfunction

  task automatic check(input string req, input logic [CW_W-1:0] got,
                       input logic [CW_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s strobe %0d: got %h expected %h", req, nstb, got, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [2:0] fe, input logic [31:0] d);
    bit synced;
    synced = (sync_state == 3'd6);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_fld_en = fe; reg_wdata = d;
    // model update
    if (a == 2'd0) begin
      if (fe[0]) m_entry = int'(d[7:0]);
      if (fe[1]) m_seq = int'(d[10:8]);
      if (fe[2] && synced) m_en[m_entry] = d[16];
    end else if (a == 2'd1) begin
      if (synced && m_seq < nsec_of(int'(rate_sel))) m_data[m_entry][m_seq] = d;
    end else if (a == 2'd2) begin
      m_master = d[0];
    end
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic idx_write(input logic [2:0] fe, input int e, input int sq, input bit ins);
    reg_write(2'd0, fe, {15'd0, ins, 5'd0, 3'(sq), 8'(e)});
  endtask

  // Writes all five sections at the current rate, then commits insert = 1.
  task automatic prog_entry(input int e, input logic [7:0] tag);
    idx_write(3'b011, e, 0, 1'b0);
    for (int s = 0; s < NSEC; s++) begin
      idx_write(3'b010, 0, s, 1'b0);
      reg_write(2'd1, 3'b000, {tag, 8'(e), 8'(s), 8'h3C});
    end
    idx_write(3'b100, 0, 0, 1'b1);
  endtask

  task automatic strobe(input string req);
    logic [CW_W-1:0] d, exp;
    bit              ins;
    int              ns;
    @(negedge clk);
    d = mk_dflt(nstb);
    slot_stb = 1'b1;
    dflt_cw  = d;
    ins = m_master && m_en[m_ptr];
    ns  = nsec_of(int'(rate_sel));
    for (int s = 0; s < NSEC; s++)
      exp[s*32 +: 32] = (ins && s < ns) ? m_data[m_ptr][s] : d[s*32 +: 32];
    @(negedge clk);
    slot_stb = 1'b0;
    // R2: valid one cycle after the strobe; R3: position follows strobe count
    check({req, " R2 vld"}, CW_W'(tx_cw_vld), CW_W'(1'b1));
    check({req, " R3 ins"}, CW_W'(tx_cw_ins), CW_W'(ins));
    check({req, ins ? " R5 word" : " R4 word"}, tx_cw, exp);
    m_ptr = (m_ptr + 1) % NENT;
    nstb++;
    @(negedge clk);
    check({req, " R2 idle"}, CW_W'(tx_cw_vld), CW_W'(1'b0));
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < NENT; i++) strobe(req);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int e = 0; e < NENT; e++) begin
      m_en[e] = 0;
      for (int s = 0; s < NSEC; s++) m_data[e][s] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: reset outputs
    check("R1 vld in reset", CW_W'(tx_cw_vld), '0);
    check("R1 word in reset", tx_cw, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 vld after reset", CW_W'(tx_cw_vld), '0);
    check("R1 ins after reset", CW_W'(tx_cw_ins), '0);
    check("R1 word after reset", tx_cw, '0);
    strobe("R1 first");

    // R8: programming before sync is ignored
    sync_state = 3'd3;
    rate_sel   = 3'd4;
    prog_entry(5, 8'h11);
    prog_entry(200, 8'h12);
    reg_write(2'd2, 3'b000, 32'd1);
    sweep("R8");

    // R11: vendor positions with master on at full rate
    sync_state = 3'd6;
    for (int k = 0; k < 4; k++) prog_entry(16 + 64 * k, 8'h20 + 8'(k));
    sweep("R11");

    // R4: master off -> pass-through everywhere
    reg_write(2'd2, 3'b000, 32'd0);
    sweep("R4");
    reg_write(2'd2, 3'b000, 32'd1);

    // R6/R7: narrow-rate rewrite over full-rate content
    for (int r = 0; r < 4; r++) begin
      rate_sel = 3'd4;
      prog_entry(30 + r, 8'hA0 + 8'(r));
      rate_sel = 3'(r);
      prog_entry(30 + r, 8'hB0 + 8'(r));
      sweep("R6");
    end
    rate_sel = 3'd4;
    sweep("R7");
    rate_sel = 3'd7;
    sweep("R6 high code");

    // R9: field-selective index writes
    rate_sel = 3'd4;
    idx_write(3'b001, 50, 7, 1'b1);       // entry only; no commit, seq untouched
    for (int s = 0; s < NSEC; s++) begin
      idx_write(3'b010, 99, s, 1'b1);     // seq only
      reg_write(2'd1, 3'b000, {8'h5A, 8'd50, 8'(s), 8'hE1});
    end
    idx_write(3'b100, 77, 3, 1'b1);       // commit only, applies to entry 50
    sweep("R9");

    // R10: clearing insert restores pass-through at that position
    idx_write(3'b101, 16, 0, 1'b0);
    idx_write(3'b101, 144, 0, 1'b0);
    sweep("R10");

    // R8: commit while out of sync is ignored
    sync_state = 3'd5;
    idx_write(3'b101, 80, 0, 1'b0);
    reg_write(2'd1, 3'b000, 32'hDEAD_BEEF);
    sweep("R8 late");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule